// File: doc/BRIEF.md
# Supervisory Reset Generator with Edge-Kicked Watchdog

This block drives an active-low system reset from two sources: a digitised supply-monitor comparator and a watchdog that expects activity on a three-state service input. The monitor bit first passes a glitch filter. Reset is held for as long as the filtered supply is low. It is then held for a fixed stretch time after the supply recovers.

Once reset is released, the watchdog counts time-base ticks. A transition of either polarity on the service input restarts the count. If the count expires, reset is pulsed low for the same stretch time. The watchdog is idle in two cases: while the service input floats, and while the power-path mode logic reports that both supply switches are off. All time constants are counted in ticks of the `tick_i` strobe and are parameters, so a bench can use short values.

Top module: `rst_gen_wdog`

## Requirements
- R1: While `rst_ni` is low, and afterwards until the filtered monitor has been high for the full stretch time, `rst_no` is 0. After reset the filtered monitor state is "low".
- R2: When `vm_ok_i` stays 0 for FILT_TICKS consecutive ticks, `rst_no` goes to 0 one clock after the filter output changes, and it stays 0 while the filtered monitor is low.
- R3: A change of `vm_ok_i` that lasts fewer than FILT_TICKS consecutive ticks has no effect on `rst_no`.
- R4: After the filtered monitor returns high, `rst_no` stays 0 for STRETCH_TICKS further ticks and then returns to 1.
- R5: While `rst_no` is 1 and the watchdog is enabled, WDOG_TICKS ticks without a kick drive `rst_no` to 0 for STRETCH_TICKS ticks.
- R6: A rising or a falling transition of `wde_lvl_i` while `wde_hiz_i` is 0 restarts the watchdog count.
- R7: While `wde_hiz_i` is 1 the watchdog is held cleared and never causes a reset.
- R8: While `wd_off_i` is 1 the watchdog is held cleared and never causes a reset.
- R9: The watchdog count is held at zero while `rst_no` is 0. It starts on the first tick after release.
- R10: If the filtered monitor drops during a reset pulse, the full STRETCH_TICKS delay restarts once it recovers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base strobe, one clock wide |
| vm_ok_i | input | 1 | Supply monitor above threshold |
| wde_lvl_i | input | 1 | Sensed level of the watchdog service input |
| wde_hiz_i | input | 1 | Service input is floating |
| wd_off_i | input | 1 | Both power-path switches are off |
| rst_no | output | 1 | Active-low system reset |

## Verification
A watchdog count that is not cleared shows up at `rst_no` as a timeout pulse that comes early or late relative to the last kick or the release. The bench therefore checks the exact clock of every edge of `rst_no`. A filter count that survives a glitch shortens the next filter interval, and a stuck stretch counter changes how long the pulse lasts. Each of these faults shows within one filter or stretch interval of the stimulus that exposes it. Hidden states are forced into view through the port: a monitor drop in the middle of a pulse, service edges of both polarities, and long idle spans with the watchdog disabled.

// File: rtl/rgw_pkg.sv
package rgw_pkg;
  // defaults assume a 10 us tick
  localparam int unsigned FILT_DEF    = 20;      // 200 us
  localparam int unsigned STRETCH_DEF = 20000;   // 200 ms
  localparam int unsigned WDOG_DEF    = 160000;  // 1.6 s

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/rgw_vm_filter.sv
module rgw_vm_filter #(
  parameter int unsigned FILT_TICKS = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic vm_ok_i,
  output logic vm_f_o
);
  localparam int unsigned CW = rgw_pkg::cnt_w(FILT_TICKS);

  logic [CW-1:0] cnt_q;
  logic          vm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      vm_q  <= 1'b0;
    end else if (vm_ok_i == vm_q) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == CW'(FILT_TICKS - 1)) begin
        vm_q  <= vm_ok_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign vm_f_o = vm_q;

  // filtered state only moves on a tick
  p_filt_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vm_q != $past(vm_q)) |-> $past(tick_i));
  p_filt_follows_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vm_q != $past(vm_q)) |-> (vm_q == $past(vm_ok_i)));
endmodule

// File: rtl/rgw_wde_edge.sv
module rgw_wde_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic hiz_i,
  output logic kick_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  // either polarity kicks; floating input never does
  assign kick_o = !hiz_i && (lvl_i != prev_q);
endmodule

// File: rtl/rgw_wdog.sv
module rgw_wdog #(
  parameter int unsigned WDOG_TICKS = 160000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic en_i,
  input  logic kick_i,
  input  logic rst_n_i,
  output logic timeout_o
);
  localparam int unsigned CW = rgw_pkg::cnt_w(WDOG_TICKS);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end    = (cnt_q == CW'(WDOG_TICKS - 1));
  assign timeout_o = tick_i && en_i && !kick_i && rst_n_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (!rst_n_i || !en_i || kick_i) cnt_q <= '0;
    else if (tick_i)                    cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(WDOG_TICKS - 1));
  p_clear_in_reset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_n_i |=> (cnt_q == '0));
  p_clear_disabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_q == '0));
  p_kick_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> (cnt_q == '0));
endmodule

// File: rtl/rgw_stretch.sv
module rgw_stretch #(
  parameter int unsigned STRETCH_TICKS = 20000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic vm_f_i,
  input  logic timeout_i,
  output logic rst_n_o
);
  localparam int unsigned CW = rgw_pkg::cnt_w(STRETCH_TICKS);

  logic [CW-1:0] cnt_q;
  logic          rst_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      rst_n_q <= 1'b0;
    end else if (!vm_f_i || timeout_i) begin
      cnt_q   <= '0;
      rst_n_q <= 1'b0;
    end else if (!rst_n_q && tick_i) begin
      if (cnt_q == CW'(STRETCH_TICKS - 1)) begin
        rst_n_q <= 1'b1;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign rst_n_o = rst_n_q;

  p_low_on_vm_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vm_f_i |=> !rst_n_q);
  p_release_needs_vm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_n_q) |-> ($past(vm_f_i) && $past(tick_i)));
  p_timeout_pulls_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_i |=> !rst_n_q);
endmodule

// File: rtl/rst_gen_wdog.sv
module rst_gen_wdog #(
  parameter int unsigned FILT_TICKS    = rgw_pkg::FILT_DEF,
  parameter int unsigned STRETCH_TICKS = rgw_pkg::STRETCH_DEF,
  parameter int unsigned WDOG_TICKS    = rgw_pkg::WDOG_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic vm_ok_i,
  input  logic wde_lvl_i,
  input  logic wde_hiz_i,
  input  logic wd_off_i,
  output logic rst_no
);
  logic vm_f, kick, wd_en, timeout, rst_n_int;

  assign wd_en = !wde_hiz_i && !wd_off_i;

  rgw_vm_filter #(.FILT_TICKS(FILT_TICKS)) u_filt (
    .clk_i, .rst_ni, .tick_i, .vm_ok_i, .vm_f_o(vm_f)
  );

  rgw_wde_edge u_edge (
    .clk_i, .rst_ni, .lvl_i(wde_lvl_i), .hiz_i(wde_hiz_i), .kick_o(kick)
  );

  rgw_wdog #(.WDOG_TICKS(WDOG_TICKS)) u_wdog (
    .clk_i, .rst_ni, .tick_i, .en_i(wd_en), .kick_i(kick),
    .rst_n_i(rst_n_int), .timeout_o(timeout)
  );

  rgw_stretch #(.STRETCH_TICKS(STRETCH_TICKS)) u_str (
    .clk_i, .rst_ni, .tick_i, .vm_f_i(vm_f), .timeout_i(timeout),
    .rst_n_o(rst_n_int)
  );

  assign rst_no = rst_n_int;

  p_no_timeout_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_off_i |=> !$fell(rst_no) || !$past(vm_f, 1) || !vm_f);
endmodule

// File: tb/rst_gen_wdog_bench.sv
module rst_gen_wdog_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned FILT = 4;
  localparam int unsigned STR  = 10;
  localparam int unsigned WD   = 20;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick = 1'b1;
  logic vm_ok = 1'b0;
  logic wde_lvl = 1'b0;
  logic wde_hiz = 1'b0;
  logic wd_off = 1'b0;
  logic rst_no;

  int unsigned cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    int unsigned at;
    logic        val;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_gen_wdog #(.FILT_TICKS(FILT), .STRETCH_TICKS(STR), .WDOG_TICKS(WD)) u_rst_gen_wdog (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .vm_ok_i(vm_ok),
    .wde_lvl_i(wde_lvl), .wde_hiz_i(wde_hiz), .wd_off_i(wd_off), .rst_no(rst_no)
  );

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;

  task automatic check(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d rst_no actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  task automatic push(input int unsigned at, input logic v, input string tag);
    exp_t e;
    e.at = at; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_cyc(input int unsigned n);
    while (cyc < n) @(negedge clk);
  endtask

  // monitor: pops expectations whose cycle has arrived
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.at < cyc) begin
        n_chk++; n_fail++;
        $display("FAIL %s missed slot %0d actual=- expected=%b", e.tag, e.at, e.val);
      end else begin
        check(rst_no, e.val, e.tag);
      end
    end
  end

  initial begin
    int unsigned c, r, k, k2, h, w, t, d;
    repeat (3) @(negedge clk);
    check(rst_no, 1'b0, "R1 in reset");
    rst_ni = 1'b1;
    // R1: monitor low after reset keeps reset asserted
    push(5, 1'b0, "R1 after reset");
    wait_cyc(6);
    c = cyc; vm_ok = 1'b1;
    push(c + FILT + STR - 1, 1'b0, "R4 still held");
    push(c + FILT + STR,     1'b1, "R4 released");
    r = c + FILT + STR;
    // R5/R9: no kicks, timeout counted from release
    push(r + WD - 1,       1'b1, "R9 count starts at release");
    push(r + WD,           1'b0, "R5 timeout pulse");
    push(r + WD + STR - 1, 1'b0, "R5 pulse length");
    push(r + WD + STR,     1'b1, "R5 pulse end");
    // R6: rising then falling kicks
    k = r + WD + STR + 5;
    wait_cyc(k); wde_lvl = 1'b1;
    push(k + 15, 1'b1, "R6 rising kick");
    k2 = k + 15;
    wait_cyc(k2); wde_lvl = 1'b0;
    push(k2 + WD,           1'b1, "R6 falling kick");
    push(k2 + WD + 1,       1'b0, "R6 timeout after falling kick");
    push(k2 + WD + STR + 1, 1'b1, "R5 second pulse end");
    // R7: floating input disables watchdog
    h = k2 + WD + STR + 3;
    wait_cyc(h); wde_hiz = 1'b1;
    push(h + 25, 1'b1, "R7 hiz no timeout");
    push(h + 50, 1'b1, "R7 hiz still high");
    // R3: short monitor glitch
    wait_cyc(h + 51); c = cyc; vm_ok = 1'b0;
    wait_cyc(c + FILT - 1); vm_ok = 1'b1;
    push(c + FILT + 2, 1'b1, "R3 glitch ignored");
    push(c + FILT + 8, 1'b1, "R3 glitch still ignored");
    // R2/R4: monitor drop that passes the filter
    wait_cyc(c + 12); c = cyc; vm_ok = 1'b0;
    push(c + FILT,     1'b1, "R2 before filter");
    push(c + FILT + 1, 1'b0, "R2 reset on drop");
    wait_cyc(c + FILT); vm_ok = 1'b1;
    push(c + 2*FILT + STR - 1, 1'b0, "R4 held after recovery");
    push(c + 2*FILT + STR,     1'b1, "R4 release after recovery");
    // R8: power path off disables watchdog
    w = c + 2*FILT + STR + 2;
    wait_cyc(w); wde_hiz = 1'b0; wd_off = 1'b1;
    push(w + 25, 1'b1, "R8 off no timeout");
    push(w + 50, 1'b1, "R8 off still high");
    // R10: monitor drop inside a watchdog pulse
    wait_cyc(w + 51); w = cyc; wd_off = 1'b0;
    t = w + WD;
    push(t, 1'b0, "R5 pulse before drop");
    d = t + 3;
    wait_cyc(d); vm_ok = 1'b0;
    wait_cyc(d + FILT); vm_ok = 1'b1;
    push(d + 10,              1'b0, "R10 pulse extended");
    push(d + 2*FILT + STR - 1, 1'b0, "R10 held before restart end");
    push(d + 2*FILT + STR,     1'b1, "R10 release after restart");
    wait_cyc(d + 2*FILT + STR + 2);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule